// File: doc/BRIEF.md
# Battery-Domain Week Timer

This block keeps time from a 32.768 kHz base clock using three counters. A free-running 15-bit prescaler divides the base clock down to a one-second step and to a programmable sub-second tick. A 32-bit week counter advances once per second, and an alarm value is compared against it. A 16-bit sub-week down-counter is stepped from a selectable source. The source can be the sub-second tick, the one-second step, or the rising edge of one of four week-counter bits. When the sub-week counter runs out it raises an expiry pulse. It then either reloads or stays at zero.

Software sees the block through a flat write port and a combinational read port on a 3-bit address. Three one-cycle event outputs report an alarm match, a sub-week expiry and each sub-second tick. With the defaults the timer spans intervals from one base period (about 30 µs) up to well over a century of seconds. Only the block's own reset clears the counters.

Top module: `batt_week_timer`

## Requirements
- R1: After reset every readable register reads zero and the three event outputs are low.
- R2: With the control enable (bit 0 at address 0) set, the week counter (address 1) rises by exactly one on every 32768th base cycle. It wraps from all ones to zero. The prescaler is cleared while enable is low, so the first step comes 32768 cycles after enable is set.
- R3: The alarm output pulses for one cycle in the cycle in which a one-second step first brings the week counter to the alarm value (address 2). Writing the week counter or the alarm never causes a pulse.
- R4: The sub-second rate code (address 5, bits 3:0) gives a one-cycle tick every 32768/f base cycles. Codes 1 to 8 select f = 2^code Hz, and codes 9 to 14 select f = 2^(code+1) Hz, so 512 Hz is never produced. Codes 0 and 15 give no tick.
- R5: While enable is low there is no sub-second tick, no sub-week step and no alarm.
- R6: The sub-week source code (address 6, bits 2:0) selects how the counter steps: 1 steps on each sub-second tick, 2 on each one-second step, and 3, 4, 5 and 6 on the rising edge of week bit 3, 5, 7 and 9, the step landing one cycle after the edge. Codes 0 and 7 never step the counter.
- R7: When a step takes the sub-week counter (read at address 4) from 1 to 0, the expiry output pulses once. The counter then loads the reload value if control bit 3 is set and otherwise stays at zero, taking no further steps.
- R8: A write to address 3 sets the reload value and loads the counter with it at the same edge.
- R9: Control bits 3:0 read back as written. A write to address 4 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 32 | Combinational read data |
| alarm_evt | output | 1 | One-cycle alarm match pulse |
| subwk_evt | output | 1 | One-cycle sub-week expiry pulse |
| subsec_tick | output | 1 | One-cycle sub-second tick |

## Verification
A corrupted prescaler shows up as a week-counter step that arrives early or late against a cycle-exact 32768 boundary. It also shows up as a sub-second pulse count over a whole number of periods that differs from the expected count. Both can be seen within one tick period or one second. A wrong sub-week count or a missed tap edge shows in the count read two cycles after the second boundary. It also shows as an expiry-pulse count over a window that is a multiple of the reload value. A wrong alarm compare shows as a pulse in the wrong cycle, a missing pulse, or a pulse caused by a write.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

   localparam int ADDR_W    = 3;
   localparam int RATE_W    = 4;
   localparam int SRC_W     = 3;
   localparam int CTRL_W    = 4;
   localparam int NTAP      = 4;
   localparam int TAP_LO    = 3;
   localparam int TAP_STEP  = 2;
   localparam int TOP_TAP   = TAP_LO + TAP_STEP * (NTAP - 1);
   localparam int MAX_SHIFT = 15;

   localparam int CTRL_EN     = 0;
   localparam int CTRL_RELOAD = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL   = 3'd0,
      RA_WEEK   = 3'd1,
      RA_ALARM  = 3'd2,
      RA_RELOAD = 3'd3,
      RA_SWCNT  = 3'd4,
      RA_RATE   = 3'd5,
      RA_SRC    = 3'd6
   } reg_addr_e;

   typedef enum logic [SRC_W-1:0] {
      SRC_OFF    = 3'd0,
      SRC_SUBSEC = 3'd1,
      SRC_SEC    = 3'd2,
      SRC_TAP_A  = 3'd3,
      SRC_TAP_B  = 3'd4,
      SRC_TAP_C  = 3'd5,
      SRC_TAP_D  = 3'd6
   } swk_src_e;

   // log2 of the tick rate in Hz; zero means no tick
   function automatic logic [4:0] rate_log2(input logic [RATE_W-1:0] code);
      if (code >= 4'd1 && code <= 4'd8)
         return {1'b0, code};
      else if (code >= 4'd9 && code <= 4'd14)
         return {1'b0, code} + 5'd1;
      else
         return 5'd0;
   endfunction

endpackage

// File: rtl/bwt_divider.sv
module bwt_divider
   import bwt_pkg::*;
#(
   parameter int LOG2_BASE = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [RATE_W-1:0] rate_code,
   output logic              sec_hit,
   output logic              sub_hit,
   output logic              sub_tick
);

   logic [LOG2_BASE-1:0] pre_q;
   logic [LOG2_BASE-1:0] mask;
   logic [4:0]           shift;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (!en)
         pre_q <= '0;
      else
         pre_q <= pre_q + 1'b1;
   end

   always_comb begin
      shift   = rate_log2(rate_code);
      mask    = {LOG2_BASE{1'b1}} >> shift;
      sec_hit = en && (&pre_q);
      sub_hit = en && (shift != 5'd0) && ((pre_q & mask) == mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sub_tick <= 1'b0;
      else
         sub_tick <= sub_hit;
   end

endmodule

// File: rtl/bwt_week.sv
module bwt_week
   import bwt_pkg::*;
#(
   parameter int WEEK_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              sec_hit,
   input  logic              week_wr,
   input  logic              alarm_wr,
   input  logic [WEEK_W-1:0] wdata,
   output logic [WEEK_W-1:0] week_q,
   output logic [WEEK_W-1:0] alarm_q,
   output logic              alarm_evt,
   output logic [NTAP-1:0]   tap_rise
);

   logic [WEEK_W-1:0] week_nxt;
   logic [NTAP-1:0]   tap_prev;

   assign week_nxt = week_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         week_q    <= '0;
         alarm_q   <= '0;
         alarm_evt <= 1'b0;
      end else begin
         if (week_wr)
            week_q <= wdata;
         else if (sec_hit)
            week_q <= week_nxt;
         if (alarm_wr)
            alarm_q <= wdata;
         alarm_evt <= sec_hit && !week_wr && !alarm_wr && (week_nxt == alarm_q);
      end
   end

   for (genvar i = 0; i < NTAP; i++) begin : g_tap
      localparam int BIT = TAP_LO + TAP_STEP * i;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            tap_prev[i] <= 1'b0;
         else
            tap_prev[i] <= week_q[BIT];
      end
      assign tap_rise[i] = en && week_q[BIT] && !tap_prev[i];
   end

endmodule

// File: rtl/bwt_subweek.sv
module bwt_subweek
   import bwt_pkg::*;
#(
   parameter int SUBWK_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en,
   input  logic [SRC_W-1:0]   src,
   input  logic               sub_hit,
   input  logic               sec_hit,
   input  logic [NTAP-1:0]    tap_rise,
   input  logic               reload_en,
   input  logic               load,
   input  logic [SUBWK_W-1:0] load_val,
   output logic [SUBWK_W-1:0] cnt_q,
   output logic [SUBWK_W-1:0] reload_q,
   output logic               expire
);

   logic step;
   logic last;

   always_comb begin
      case (src)
         SRC_SUBSEC: step = sub_hit;
         SRC_SEC:    step = sec_hit;
         SRC_TAP_A:  step = tap_rise[0];
         SRC_TAP_B:  step = tap_rise[1];
         SRC_TAP_C:  step = tap_rise[2];
         SRC_TAP_D:  step = tap_rise[3];
         default:    step = 1'b0;
      endcase
      step = step && en;
      last = (cnt_q == SUBWK_W'(1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         reload_q <= '0;
         expire   <= 1'b0;
      end else begin
         expire <= step && last && !load;
         if (load) begin
            reload_q <= load_val;
            cnt_q    <= load_val;
         end else if (step && (cnt_q != '0)) begin
            if (last)
               cnt_q <= reload_en ? reload_q : '0;
            else
               cnt_q <= cnt_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/batt_week_timer.sv
module batt_week_timer
   import bwt_pkg::*;
#(
   parameter int LOG2_BASE = 15,
   parameter int WEEK_W    = 32,
   parameter int SUBWK_W   = 16,
   parameter int DATA_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              alarm_evt,
   output logic              subwk_evt,
   output logic              subsec_tick
);

   if (LOG2_BASE < MAX_SHIFT) begin : g_bad_base
      $error("LOG2_BASE must cover the fastest sub-second rate");
   end
   if (WEEK_W <= TOP_TAP || WEEK_W > DATA_W) begin : g_bad_week
      $error("WEEK_W must hold the highest tap bit and fit the data port");
   end
   if (SUBWK_W < 1 || SUBWK_W > DATA_W) begin : g_bad_subwk
      $error("SUBWK_W must fit the data port");
   end

   logic [CTRL_W-1:0]  ctrl_q;
   logic [RATE_W-1:0]  rate_q;
   logic [SRC_W-1:0]   src_q;
   logic               en;
   logic               wr_ctrl, wr_week, wr_alarm, wr_reload, wr_rate, wr_src;
   logic               sec_hit, sub_hit;
   logic [NTAP-1:0]    tap_rise;
   logic [WEEK_W-1:0]  week_q, alarm_q;
   logic [SUBWK_W-1:0] swc_q, reload_q;

   assign en = ctrl_q[CTRL_EN];

   always_comb begin
      wr_ctrl   = wr_en && (wr_addr == RA_CTRL);
      wr_week   = wr_en && (wr_addr == RA_WEEK);
      wr_alarm  = wr_en && (wr_addr == RA_ALARM);
      wr_reload = wr_en && (wr_addr == RA_RELOAD);
      wr_rate   = wr_en && (wr_addr == RA_RATE);
      wr_src    = wr_en && (wr_addr == RA_SRC);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         rate_q <= '0;
         src_q  <= '0;
      end else begin
         if (wr_ctrl) ctrl_q <= wr_data[CTRL_W-1:0];
         if (wr_rate) rate_q <= wr_data[RATE_W-1:0];
         if (wr_src)  src_q  <= wr_data[SRC_W-1:0];
      end
   end

   bwt_divider #(.LOG2_BASE(LOG2_BASE)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .rate_code (rate_q),
      .sec_hit   (sec_hit),
      .sub_hit   (sub_hit),
      .sub_tick  (subsec_tick)
   );

   bwt_week #(.WEEK_W(WEEK_W)) u_week (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .sec_hit   (sec_hit),
      .week_wr   (wr_week),
      .alarm_wr  (wr_alarm),
      .wdata     (wr_data[WEEK_W-1:0]),
      .week_q    (week_q),
      .alarm_q   (alarm_q),
      .alarm_evt (alarm_evt),
      .tap_rise  (tap_rise)
   );

   bwt_subweek #(.SUBWK_W(SUBWK_W)) u_subwk (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .src       (src_q),
      .sub_hit   (sub_hit),
      .sec_hit   (sec_hit),
      .tap_rise  (tap_rise),
      .reload_en (ctrl_q[CTRL_RELOAD]),
      .load      (wr_reload),
      .load_val  (wr_data[SUBWK_W-1:0]),
      .cnt_q     (swc_q),
      .reload_q  (reload_q),
      .expire    (subwk_evt)
   );

   always_comb begin
      case (rd_addr)
         RA_CTRL:   rd_data = DATA_W'(ctrl_q);
         RA_WEEK:   rd_data = DATA_W'(week_q);
         RA_ALARM:  rd_data = DATA_W'(alarm_q);
         RA_RELOAD: rd_data = DATA_W'(reload_q);
         RA_SWCNT:  rd_data = DATA_W'(swc_q);
         RA_RATE:   rd_data = DATA_W'(rate_q);
         RA_SRC:    rd_data = DATA_W'(src_q);
         default:   rd_data = '0;
      endcase
   end

endmodule

// File: rtl/bwt_checker.sv
module bwt_checker #(
   parameter int WEEK_W  = 32,
   parameter int SUBWK_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en,
   input logic               reload_en,
   input logic [3:0]         rate,
   input logic [2:0]         src,
   input logic               week_wr,
   input logic               reload_wr,
   input logic [WEEK_W-1:0]  week_q,
   input logic [WEEK_W-1:0]  alarm_q,
   input logic [SUBWK_W-1:0] swc,
   input logic [SUBWK_W-1:0] reload_q,
   input logic               alarm_evt,
   input logic               subwk_evt,
   input logic               subsec_tick
);

   // R3: a pulse only where counter and alarm agree
   p_alarm_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_evt |-> (week_q == alarm_q));

   // R3: a week write never produces the pulse
   p_alarm_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_evt |-> !$past(week_wr));

   // R2: the counter only moves by one, and only while enabled
   p_week_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(week_wr) && (week_q != $past(week_q))) |->
         ((week_q == $past(week_q) + 1'b1) && $past(en)));

   // R5: silence while disabled
   p_quiet_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(en) |-> (!subsec_tick && !subwk_evt && !alarm_evt));

   // R4: codes 0 and 15 give no tick
   p_rate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(rate) == 4'd0) || ($past(rate) == 4'd15)) |-> !subsec_tick);

   // R6: codes 0 and 7 freeze the sub-week counter
   p_src_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(src) == 3'd0) || ($past(src) == 3'd7)) && !$past(reload_wr)) |-> $stable(swc));

   // R7: after expiry the counter holds the reload value or zero
   p_expire_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (subwk_evt && !$past(reload_wr)) |->
         (swc == ($past(reload_en) ? $past(reload_q) : '0)));

   // R7: outside expiry and loads the counter moves down by one
   p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(reload_wr) && (swc != $past(swc))) |->
         ((swc == $past(swc) - 1'b1) || subwk_evt));

   // R8: a reload write loads the counter
   p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reload_wr) |-> (swc == reload_q));

endmodule

bind batt_week_timer bwt_checker #(.WEEK_W(WEEK_W), .SUBWK_W(SUBWK_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .en          (en),
   .reload_en   (ctrl_q[3]),
   .rate        (rate_q),
   .src         (src_q),
   .week_wr     (wr_week),
   .reload_wr   (wr_reload),
   .week_q      (week_q),
   .alarm_q     (alarm_q),
   .swc         (swc_q),
   .reload_q    (reload_q),
   .alarm_evt   (alarm_evt),
   .subwk_evt   (subwk_evt),
   .subsec_tick (subsec_tick)
);

// File: tb/tb_batt_week_timer.sv
module tb_batt_week_timer;
   import bwt_pkg::*;

   localparam int SEC = 32768;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        alarm_evt, subwk_evt, subsec_tick;

   always #4 clk = ~clk;

   batt_week_timer dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .alarm_evt(alarm_evt),
      .subwk_evt(subwk_evt), .subsec_tick(subsec_tick)
   );

   int cyc = 0;
   int checks = 0;
   int errors = 0;
   int n_sub = 0, n_sw = 0, n_al = 0;
   bit done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (subsec_tick) n_sub++;
         if (subwk_evt)   n_sw++;
         if (alarm_evt)   n_al++;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // scoreboard of expected register reads
   typedef struct {
      logic [2:0]  addr;
      logic [31:0] exp;
      string       req;
   } rd_item_t;
   rd_item_t sb_q[$];

   always begin
      wait (sb_q.size() > 0);
      #1;
      chk(rd_data === sb_q[0].exp, sb_q[0].req, $sformatf("read addr %0d", sb_q[0].addr),
          rd_data, sb_q[0].exp);
      void'(sb_q.pop_front());
   end

   // reads in the current cycle; caller sits just after a falling edge
   task automatic expect_rd(input logic [2:0] a, input logic [31:0] e, input string req);
      rd_item_t it;
      it.addr = a; it.exp = e; it.req = req;
      rd_addr = a;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d, output int edge_no);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      edge_no = cyc;
   endtask

   task automatic wait_cyc(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic count_win(input int n, output int sub, output int sw, output int al);
      int s0, w0, a0;
      #1; s0 = n_sub; w0 = n_sw; a0 = n_al;
      repeat (n) @(negedge clk);
      #1; sub = n_sub - s0; sw = n_sw - w0; al = n_al - a0;
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
         summary();
         $finish;
      end
   end

   initial begin
      int e, p, s, w, a;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!alarm_evt && !subwk_evt && !subsec_tick, "R1", "events in reset",
          {alarm_evt, subwk_evt, subsec_tick}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int i = 0; i < 7; i++) expect_rd(3'(i), 32'd0, "R1");

      // R4: sub-second rate table, enable with reload on
      wr(RA_RATE, 32'd14, e);
      wr(RA_CTRL, 32'h9, p);
      count_win(64, s, w, a);
      chk(s == 64, "R4", "32768 Hz ticks", s, 64);
      wr(RA_RATE, 32'd9, e); repeat (3) @(negedge clk);
      count_win(320, s, w, a);
      chk(s == 10, "R4", "code 9 is 1024 Hz", s, 10);
      wr(RA_RATE, 32'd8, e); repeat (3) @(negedge clk);
      count_win(1280, s, w, a);
      chk(s == 10, "R4", "code 8 is 256 Hz", s, 10);
      wr(RA_RATE, 32'd4, e); repeat (3) @(negedge clk);
      count_win(4096, s, w, a);
      chk(s == 2, "R4", "code 4 is 16 Hz", s, 2);
      wr(RA_RATE, 32'd0, e); repeat (3) @(negedge clk);
      count_win(300, s, w, a);
      chk(s == 0, "R4", "code 0 silent", s, 0);
      wr(RA_RATE, 32'd15, e); repeat (3) @(negedge clk);
      count_win(300, s, w, a);
      chk(s == 0, "R4", "code 15 silent", s, 0);

      // R7 / R8: sub-week with reload, stepped every cycle
      wr(RA_RATE, 32'd14, e);
      wr(RA_SRC, 32'd1, e);
      wr(RA_RELOAD, 32'd5, e);
      expect_rd(RA_SWCNT, 32'd5, "R8");
      count_win(50, s, w, a);
      chk(w == 10, "R7", "expiries with reload", w, 10);
      wr(RA_CTRL, 32'h1, e);
      wr(RA_RELOAD, 32'd5, e);
      count_win(20, s, w, a);
      chk(w == 1, "R7", "single expiry without reload", w, 1);
      expect_rd(RA_SWCNT, 32'd0, "R7");

      // R6: disabled sources
      wr(RA_SRC, 32'd0, e);
      wr(RA_RELOAD, 32'd9, e);
      repeat (100) @(negedge clk);
      expect_rd(RA_SWCNT, 32'd9, "R6");
      wr(RA_SRC, 32'd7, e);
      repeat (100) @(negedge clk);
      expect_rd(RA_SWCNT, 32'd9, "R6");
      // R9: count register is read-only
      wr(RA_SWCNT, 32'd3, e);
      expect_rd(RA_SWCNT, 32'd9, "R9");

      // R5 / R9: disabled with flag bits
      wr(RA_CTRL, 32'h6, e);
      expect_rd(RA_CTRL, 32'h6, "R9");
      wr(RA_SRC, 32'd1, e);
      count_win(200, s, w, a);
      chk(s == 0 && w == 0, "R5", "no tick or expiry while off", s + w, 0);
      expect_rd(RA_SWCNT, 32'd9, "R5");

      // R3: writes never fire the alarm
      wr(RA_SRC, 32'd3, e);
      wr(RA_RELOAD, 32'd100, e);
      wr(RA_WEEK, 32'd7, e);
      wr(RA_ALARM, 32'd7, e);
      wr(RA_CTRL, 32'h1, p);
      #1; a = n_al;
      wr(RA_ALARM, 32'd8, e);
      wr(RA_WEEK, 32'd7, e);
      #1;
      chk(n_al == a, "R3", "alarm after writes", n_al - a, 0);

      // R2 / R3 / R6: first second, tap on bit 3
      wait_cyc(p + SEC - 1);
      expect_rd(RA_WEEK, 32'd7, "R2");
      chk(!alarm_evt, "R3", "alarm before match", alarm_evt, 0);
      wait_cyc(p + SEC);
      expect_rd(RA_WEEK, 32'd8, "R2");
      chk(alarm_evt, "R3", "alarm at match", alarm_evt, 1);
      wait_cyc(p + SEC + 1);
      chk(!alarm_evt, "R3", "alarm one cycle wide", alarm_evt, 0);
      wait_cyc(p + SEC + 2);
      expect_rd(RA_SWCNT, 32'd99, "R6");

      // R6: tap on bit 5 in the second second
      wr(RA_SRC, 32'd4, e);
      wr(RA_WEEK, 32'd31, e);
      wait_cyc(p + 2 * SEC - 1);
      expect_rd(RA_SWCNT, 32'd99, "R6");
      wait_cyc(p + 2 * SEC + 2);
      expect_rd(RA_SWCNT, 32'd98, "R6");
      expect_rd(RA_WEEK, 32'd32, "R2");

      // R2 / R3 / R6: wrap to zero with alarm at zero, one-second source
      wr(RA_SRC, 32'd2, e);
      wr(RA_ALARM, 32'd0, e);
      wr(RA_WEEK, 32'hFFFF_FFFF, e);
      wait_cyc(p + 3 * SEC - 1);
      expect_rd(RA_WEEK, 32'hFFFF_FFFF, "R2");
      wait_cyc(p + 3 * SEC);
      expect_rd(RA_WEEK, 32'd0, "R2");
      expect_rd(RA_SWCNT, 32'd97, "R6");
      chk(alarm_evt, "R3", "alarm on wrap", alarm_evt, 1);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule